// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time Insertion

This block drives the two switches of a half bridge with a pair of complementary, non-overlapping pulse-width-modulated signals. A free-running period counter, clocked either on every input clock or on every second one, is compared against an active pulse-width value. Whenever the result of that comparison flips, both outputs are held low for a programmable number of input clocks before the newly selected output is allowed to go high. The high-side output follows the "counter below width" phase, and the low-side output follows the rest of the period.

A host sets the block up through a single-cycle write strobe with a one-bit register select. One register holds the pulse width. The other holds the dead time, the prescale choice, the resolution (7 or 8 bit), a stop bit and a lock bit. Once the lock bit is set, only the stop bit can still be changed, so a runaway program cannot alter the timing of a live bridge. An active-low disable pin forces both outputs low at once. Outputs that were stopped or disabled resume only at the start of a new period. Writes are accepted on every cycle. The block never stalls the host and never raises back-pressure.

Top module: `dtpwm_top`

## Requirements
- R1: The period is 256 counter steps in 8-bit mode and 128 in 7-bit mode (`res7` = bit 5 of the control word). Each step lasts one input clock, or two when `div2` (bit 4) is set, which gives periods of 128, 256 or 512 input clocks.
- R2: The high-side output follows `counter < width`, and the width is read against the current resolution. In 7-bit mode, a width of 128 or more keeps the high side on for the whole period. In 8-bit mode, a width of 128 gives half duty.
- R3: After every change of the comparator result, both outputs stay low for exactly the dead time (bits 3:0 of the control word) in input clocks. The two outputs are never high together. With the outputs running, the high side is on for width×step − dead cycles per period and the low side for (N − width)×step − dead cycles.
- R4: A width of 0 keeps the high side permanently low and the low side permanently high, with no glitch pulses.
- R5: A new width written with address 1 (data bits 7:0) takes effect only at the next period start. The period in progress finishes with the old width.
- R6: A control write (address 0) is fully accepted while the lock bit (bit 7) is clear. While the lock bit is set, such a write changes only the stop bit (bit 6). The lock can be cleared only by reset.
- R7: While `dis_n` is low, both outputs are low in the same cycle, without waiting for a clock edge.
- R8: After stop clears or `dis_n` returns high, the outputs stay low until the next period start, and they resume there only if neither control is active.
- R9: After reset, the stop bit is set, the width is 0, the dead time is 0, the prescaler divides by 1, the mode is 8-bit and the lock is clear, so both outputs are low.
- R10: Setting the stop bit forces both outputs low from the cycle that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the pulse width |
| wr_data | input | 8 | Write data |
| dis_n | input | 1 | Active-low output disable |
| out_hi | output | 1 | High-side drive |
| out_lo | output | 1 | Low-side (complementary) drive |

## Verification
The hardest case to reach from the ports is a release that happens in the middle of a period, where the outputs would be active if gating alone were lifted. The bench first fixes the period phase by timing a rising edge of the high side with zero dead time. It then applies stop or disable well into the low-side phase and releases it later in the same kind of phase. It checks that no output rises before a cycle an exact multiple of the period away from the reference edge. The double-buffered width is reached in a similar way: a new width is written in the middle of a long high phase, and the bench confirms that the edge still falls at the old width.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int DEAD_W = 4;

  // Control word: dead time in the low bits, lock in the top bit.
  typedef struct packed {
    logic              lock;
    logic              stop;
    logic              res7;
    logic              div2;
    logic [DEAD_W-1:0] dead;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{lock: 1'b0, stop: 1'b1, res7: 1'b0,
                                 div2: 1'b0, dead: '0};
endpackage

// File: rtl/dtpwm_regs.sv
module dtpwm_regs
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              boundary,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  pw_act
);
  logic [CNT_W-1:0] pw_nxt;
  ctrl_t            wr_ctrl;

  assign wr_ctrl = ctrl_t'(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RST;
      pw_nxt <= '0;
      pw_act <= '0;
    end else begin
      if (wr_en && !wr_addr) begin
        if (ctrl.lock) ctrl.stop <= wr_ctrl.stop;
        else           ctrl      <= wr_ctrl;
      end
      if (wr_en && wr_addr) pw_nxt <= wr_data[CNT_W-1:0];
      if (boundary) pw_act <= pw_nxt;
    end
  end
endmodule

// File: rtl/dtpwm_timebase.sv
module dtpwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div2,
  input  logic             res7,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary
);
  localparam logic [CNT_W-1:0] LAST_FULL = '1;
  localparam logic [CNT_W-1:0] LAST_HALF = LAST_FULL >> 1;

  logic             ph;
  logic             tick;
  logic [CNT_W-1:0] last;

  assign tick     = !div2 || ph;
  assign last     = res7 ? LAST_HALF : LAST_FULL;
  assign boundary = tick && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else begin
      ph <= ~ph;
      if (tick) cnt <= boundary ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dtpwm_outstage.sv
module dtpwm_outstage
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  pw_act,
  input  logic [DEAD_W-1:0] dead,
  input  logic              stop,
  input  logic              dis_n,
  input  logic              boundary,
  output logic              run,
  output logic              out_hi,
  output logic              out_lo
);
  logic              raw, raw_q, start_q, drive_ok;
  logic [DEAD_W-1:0] dt;

  assign raw = cnt < pw_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      start_q <= 1'b0;
      dt      <= '0;
      run     <= 1'b0;
    end else begin
      raw_q   <= raw;
      start_q <= boundary;
      if (raw != raw_q)  dt <= dead;
      else if (dt != '0) dt <= dt - 1'b1;
      if (stop || !dis_n) run <= 1'b0;
      else if (start_q)   run <= 1'b1;
    end
  end

  assign drive_ok = run && !stop && dis_n && (dt == '0);
  assign out_hi   = drive_ok && raw_q;
  assign out_lo   = drive_ok && !raw_q;
endmodule

// File: rtl/dtpwm_top.sv
module dtpwm_top
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              dis_n,
  output logic              out_hi,
  output logic              out_lo
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] pw_act;
  logic [CNT_W-1:0] cnt;
  logic             boundary;
  logic             run;

  dtpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .boundary(boundary), .ctrl(ctrl_q), .pw_act(pw_act)
  );

  dtpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .div2(ctrl_q.div2), .res7(ctrl_q.res7),
    .cnt(cnt), .boundary(boundary)
  );

  dtpwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .pw_act(pw_act),
    .dead(ctrl_q.dead), .stop(ctrl_q.stop), .dis_n(dis_n),
    .boundary(boundary), .run(run), .out_hi(out_hi), .out_lo(out_lo)
  );
endmodule

// File: rtl/dtpwm_chk.sv
module dtpwm_chk
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dis_n,
  input logic             out_hi,
  input logic             out_lo,
  input ctrl_t            ctrl_q,
  input logic [CNT_W-1:0] pw_act,
  input logic             boundary,
  input logic             run
);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi && out_lo));

  // R3
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_lo) && $past(ctrl_q.dead) >= 2) |=> !out_hi);

  // R7
  disable_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |-> (!out_hi && !out_lo));

  // R10
  stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.stop |-> (!out_hi && !out_lo));

  // R8
  resume_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(boundary, 2));

  // R6
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> (ctrl_q.lock && $stable(ctrl_q.dead) &&
                     $stable(ctrl_q.div2) && $stable(ctrl_q.res7)));

  // R5
  width_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(pw_act));
endmodule

bind dtpwm_top dtpwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dis_n(dis_n), .out_hi(out_hi), .out_lo(out_lo),
  .ctrl_q(ctrl_q), .pw_act(pw_act), .boundary(boundary), .run(run)
);

// File: tb/dtpwm_top_tb.sv
module dtpwm_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       dis_n = 1'b1;
  logic       out_hi, out_lo;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    int    per;
    int    hi;
    int    lo;
  } exp_t;
  exp_t sb[$];

  dtpwm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dis_n(dis_n), .out_hi(out_hi), .out_lo(out_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(int dead, bit div2, bit res7, bit stop, bit lock);
    return {lock, stop, res7, div2, 4'(dead)};
  endfunction

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: pushes an expectation and waits for the monitor to consume it.
  task automatic expect_win(string tag, int per, int hi, int lo);
    exp_t e;
    e.tag = tag; e.per = per; e.hi = hi; e.lo = lo;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  // Monitor: counts active cycles of each output over one window.
  initial begin
    forever begin
      int h, l;
      wait (sb.size() > 0);
      h = 0; l = 0;
      for (int i = 0; i < sb[0].per; i++) begin
        @(negedge clk);
        h += int'(out_hi);
        l += int'(out_lo);
      end
      chk({sb[0].tag, " hi"}, h, sb[0].hi);
      chk({sb[0].tag, " lo"}, l, sb[0].lo);
      void'(sb.pop_front());
    end
  end

  task automatic cfg(int pw, int dead, bit div2, bit res7, bit lock);
    wr(1'b1, 8'(pw));
    wr(1'b0, cw(dead, div2, res7, 1'b0, lock));
    repeat (1200) @(negedge clk);
  endtask

  task automatic wait_rise_hi(output int t);
    logic prev;
    prev = out_hi;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (out_hi && !prev) break;
      prev = out_hi;
    end
    t = cyc;
  endtask

  // R7 / R8 / R10: mid-period stop or disable, release, resume at start
  task automatic test_release(bit use_stop, string tag);
    int t0, t1, bad;
    cfg(64, 0, 1'b0, 1'b0, 1'b0);
    wait_rise_hi(t0);
    repeat (100) @(negedge clk);
    if (use_stop) begin
      wr(1'b0, cw(0, 1'b0, 1'b0, 1'b1, 1'b0));
      chk({tag, " R10 low after stop"}, int'(out_hi || out_lo), 0);
    end else begin
      dis_n = 1'b0;
      #1;
      chk({tag, " R7 immediate low"}, int'(out_hi || out_lo), 0);
    end
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      bad += int'(out_hi || out_lo);
    end
    chk({tag, " held low"}, bad, 0);
    if (use_stop) wr(1'b0, cw(0, 1'b0, 1'b0, 1'b0, 1'b0));
    else begin
      @(negedge clk);
      dis_n = 1'b1;
    end
    for (int i = 0; i < 1000; i++) begin
      if (out_hi || out_lo) break;
      @(negedge clk);
    end
    t1 = cyc;
    chk({tag, " R8 resume phase"}, (t1 - t0) % 256, 0);
    chk({tag, " R8 resume on high side"}, int'(out_hi), 1);
  endtask

  initial begin
    int t0, len;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9: outputs held low out of reset
    expect_win("R9 reset idle", 300, 0, 0);

    // R4: width 0, outputs enabled
    wr(1'b0, cw(3, 1'b0, 1'b0, 1'b0, 1'b0));
    repeat (600) @(negedge clk);
    expect_win("R4 zero width", 256, 0, 256);

    // R1 R3: 8-bit, divide by 1
    cfg(64, 3, 1'b0, 1'b0, 1'b0);
    expect_win("R3 8b dead3", 256, 61, 189);

    // R2: 7-bit mode, width 128 is full duty; width 64 is half
    cfg(128, 3, 1'b0, 1'b1, 1'b0);
    expect_win("R2 7b width128 full", 128, 128, 0);
    cfg(64, 3, 1'b0, 1'b1, 1'b0);
    expect_win("R1 7b period128", 128, 61, 61);

    // R1: prescaler
    cfg(64, 5, 1'b1, 1'b0, 1'b0);
    expect_win("R1 8b div2 period512", 512, 123, 379);
    cfg(32, 2, 1'b1, 1'b1, 1'b0);
    expect_win("R1 7b div2 period256", 256, 62, 190);

    // R5: width written mid high phase applies at next period
    cfg(200, 0, 1'b0, 1'b0, 1'b0);
    wait_rise_hi(t0);
    repeat (98) @(negedge clk);
    wr(1'b1, 8'd20);
    len = cyc - t0;
    while (out_hi) begin
      @(negedge clk);
      len = cyc - t0;
    end
    chk("R5 old width finishes", len, 200);
    wait_rise_hi(t0);
    len = 0;
    while (out_hi) begin
      @(negedge clk);
      len++;
    end
    chk("R5 new width next period", len, 20);

    test_release(1'b0, "dis");
    test_release(1'b1, "stop");

    // R6: lock freezes all but stop
    cfg(64, 3, 1'b0, 1'b0, 1'b1);
    wr(1'b0, cw(9, 1'b1, 1'b1, 1'b1, 1'b0));
    repeat (4) @(negedge clk);
    expect_win("R6 stop accepted while locked", 300, 0, 0);
    wr(1'b0, cw(9, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (600) @(negedge clk);
    expect_win("R6 timing frozen while locked", 256, 61, 189);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule